// File: doc/BRIEF.md
# Two-level instruction control decoder

This block turns the fields of a fetched instruction word into the control lines that steer a single-cycle datapath. It is purely combinational. The first level looks only at the 6-bit opcode. It produces the multiplexer selects, the register-file and data-memory enables, the branch and jump flags, and a 2-bit ALU class code. The second level combines that class code with the 6-bit function field and yields the 4-bit operation code for the ALU.

The datapath drives the opcode and function fields straight from the instruction word and uses every output in the same cycle. The function field is decoded only for register-register instructions; for every other class the ALU operation is fixed by the opcode. An instruction that either level does not recognise turns into a harmless bubble. Such an instruction writes nothing, enables nothing and sets the ALU to AND.

Top module: `instr_ctl_decoder`

## Requirements
- R1: The opcode classes are recognised as follows: 0 is register-register, 2 is jump, 4 is branch-if-equal, 35 is load and 43 is store. Each class gives the output pattern stated in R2 and R4 to R7.
- R2: A register-register opcode with a known function code drives `dst_sel_rd_o`=1 and `rf_we_o`=1. It drives `opb_imm_o`, `wb_from_mem_o`, `dm_re_o`, `dm_we_o`, `br_eq_o` and `jmp_o` all to 0.
- R3: Under a register-register opcode, the function code sets `alu_op_o` as follows: 0x20 gives add 4'b0010, 0x22 gives subtract 4'b0110, 0x24 gives AND 4'b0000, 0x25 gives OR 4'b0001 and 0x2A gives set-on-less-than 4'b0111.
- R4: A load drives `opb_imm_o`, `wb_from_mem_o`, `rf_we_o` and `dm_re_o` to 1 and all other flags to 0. It sets `alu_op_o` to add 4'b0010 whatever the function field holds.
- R5: A store drives `opb_imm_o` and `dm_we_o` to 1 and all other flags to 0, including `rf_we_o`, `dst_sel_rd_o` and `wb_from_mem_o`. It sets `alu_op_o` to add 4'b0010 whatever the function field holds.
- R6: A branch-if-equal drives `br_eq_o` to 1 and all other flags to 0. It sets `alu_op_o` to subtract 4'b0110 whatever the function field holds.
- R7: A jump drives `jmp_o` to 1 and all other flags to 0. It sets `alu_op_o` to 4'b0000.
- R8: Any opcode other than 0, 2, 4, 35 and 43 drives every flag to 0 and `alu_op_o` to AND 4'b0000.
- R9: A register-register opcode with a function code outside the five listed in R3 drives every flag to 0 and `alu_op_o` to AND 4'b0000.
- R10: No input pattern asserts `dm_re_o` and `dm_we_o` together. `wb_from_mem_o` is never 1 unless `dm_re_o` is 1. At most one of `br_eq_o` and `jmp_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 6 | Opcode field of the instruction |
| fn_i | input | 6 | Function field of the instruction |
| dst_sel_rd_o | output | 1 | Destination register taken from the rd field (1) or the rt field (0) |
| opb_imm_o | output | 1 | Second ALU operand is the sign-extended immediate (1) or register read data 2 (0) |
| wb_from_mem_o | output | 1 | Write-back value comes from data memory (1) or from the ALU (0) |
| rf_we_o | output | 1 | Register file write enable |
| dm_re_o | output | 1 | Data memory read enable |
| dm_we_o | output | 1 | Data memory write enable |
| br_eq_o | output | 1 | Conditional branch on ALU zero |
| jmp_o | output | 1 | Unconditional jump |
| alu_op_o | output | 4 | ALU operation code |

## Verification
The opcode decode and the function-field decode act on the same instruction word in the same cycle. They can conflict when a non-register opcode carries a function field that would be valid for a register-register instruction. They can also conflict when a register-register opcode carries a function field that the second level rejects. The bench provokes the first case by pairing loads, stores and branches with each listed function code and with unlisted ones. It judges the result by the ALU code staying at add or subtract and the flags staying unchanged. For the second case it sweeps all 64 function codes under opcode 0 and expects the full bubble for every code outside the five listed.

// File: rtl/ictl_pkg.sv
package ictl_pkg;
  localparam int OP_W  = 6;
  localparam int FN_W  = 6;
  localparam int ACL_W = 2;
  localparam int ALU_W = 4;

  // ALU class passed from the opcode stage to the function stage
  typedef enum logic [ACL_W-1:0] {
    ACL_ADD  = 2'b00,
    ACL_SUB  = 2'b01,
    ACL_FUNC = 2'b10,
    ACL_NONE = 2'b11
  } acl_e;

  localparam logic [ALU_W-1:0] ALU_AND = 4'b0000;
  localparam logic [ALU_W-1:0] ALU_OR  = 4'b0001;
  localparam logic [ALU_W-1:0] ALU_ADD = 4'b0010;
  localparam logic [ALU_W-1:0] ALU_SUB = 4'b0110;
  localparam logic [ALU_W-1:0] ALU_SLT = 4'b0111;

  localparam logic [OP_W-1:0] OPC_REG = 6'd0;
  localparam logic [OP_W-1:0] OPC_JMP = 6'd2;
  localparam logic [OP_W-1:0] OPC_BEQ = 6'd4;
  localparam logic [OP_W-1:0] OPC_LD  = 6'd35;
  localparam logic [OP_W-1:0] OPC_ST  = 6'd43;

  localparam logic [FN_W-1:0] FN_ADD = 6'h20;
  localparam logic [FN_W-1:0] FN_SUB = 6'h22;
  localparam logic [FN_W-1:0] FN_AND = 6'h24;
  localparam logic [FN_W-1:0] FN_OR  = 6'h25;
  localparam logic [FN_W-1:0] FN_SLT = 6'h2A;

  typedef struct packed {
    logic dst_rd;
    logic opb_imm;
    logic wb_mem;
    logic rf_we;
    logic dm_re;
    logic dm_we;
    logic br;
    logic jmp;
  } ctl_t;

  localparam ctl_t CTL_OFF = '0;

  typedef struct packed {
    ctl_t ctl;
    acl_e acl;
    logic known;
  } main_t;

  typedef struct packed {
    logic             known;
    logic [ALU_W-1:0] code;
  } alu_t;

  // First level: opcode to control flags and ALU class
  function automatic main_t main_decode(input logic [OP_W-1:0] op);
    main_t r;
    r.ctl   = CTL_OFF;
    r.acl   = ACL_NONE;
    r.known = 1'b1;
    case (op)
      OPC_REG: begin
        r.ctl.dst_rd = 1'b1;
        r.ctl.rf_we  = 1'b1;
        r.acl        = ACL_FUNC;
      end
      OPC_LD: begin
        r.ctl.opb_imm = 1'b1;
        r.ctl.wb_mem  = 1'b1;
        r.ctl.rf_we   = 1'b1;
        r.ctl.dm_re   = 1'b1;
        r.acl         = ACL_ADD;
      end
      OPC_ST: begin
        r.ctl.opb_imm = 1'b1;
        r.ctl.dm_we   = 1'b1;
        r.acl         = ACL_ADD;
      end
      OPC_BEQ: begin
        r.ctl.br = 1'b1;
        r.acl    = ACL_SUB;
      end
      OPC_JMP: begin
        r.ctl.jmp = 1'b1;
      end
      default: r.known = 1'b0;
    endcase
    return r;
  endfunction

  // Second level: ALU class plus function field to ALU operation
  function automatic alu_t alu_decode(input acl_e acl, input logic [FN_W-1:0] fn);
    alu_t r;
    r.known = 1'b1;
    r.code  = ALU_AND;
    case (acl)
      ACL_ADD:  r.code = ALU_ADD;
      ACL_SUB:  r.code = ALU_SUB;
      ACL_FUNC: begin
        case (fn)
          FN_ADD:  r.code = ALU_ADD;
          FN_SUB:  r.code = ALU_SUB;
          FN_AND:  r.code = ALU_AND;
          FN_OR:   r.code = ALU_OR;
          FN_SLT:  r.code = ALU_SLT;
          default: r.known = 1'b0;
        endcase
      end
      default:  r.code = ALU_AND;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/ictl_main_dec.sv
module ictl_main_dec
  import ictl_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  output ctl_t            ctl_o,
  output acl_e            acl_o,
  output logic            known_o
);
  main_t dec;

  always_comb begin
    dec     = main_decode(op_i);
    ctl_o   = dec.ctl;
    acl_o   = dec.acl;
    known_o = dec.known;
  end
endmodule

// File: rtl/ictl_alu_dec.sv
module ictl_alu_dec
  import ictl_pkg::*;
(
  input  acl_e             acl_i,
  input  logic [FN_W-1:0]  fn_i,
  output logic [ALU_W-1:0] code_o,
  output logic             known_o
);
  alu_t dec;

  always_comb begin
    dec     = alu_decode(acl_i, fn_i);
    code_o  = dec.code;
    known_o = dec.known;
  end
endmodule

// File: rtl/instr_ctl_decoder.sv
module instr_ctl_decoder
  import ictl_pkg::*;
(
  input  logic [OP_W-1:0]  op_i,
  input  logic [FN_W-1:0]  fn_i,
  output logic             dst_sel_rd_o,
  output logic             opb_imm_o,
  output logic             wb_from_mem_o,
  output logic             rf_we_o,
  output logic             dm_re_o,
  output logic             dm_we_o,
  output logic             br_eq_o,
  output logic             jmp_o,
  output logic [ALU_W-1:0] alu_op_o
);
  // Named internal events, also observed by the checker
  ctl_t             main_ctl;
  acl_e             acl;
  logic             op_known;
  logic [ALU_W-1:0] fn_code;
  logic             fn_known;
  logic             fn_reject;
  ctl_t             ctl_out;

  ictl_main_dec u_main (
    .op_i    (op_i),
    .ctl_o   (main_ctl),
    .acl_o   (acl),
    .known_o (op_known)
  );

  ictl_alu_dec u_alu (
    .acl_i   (acl),
    .fn_i    (fn_i),
    .code_o  (fn_code),
    .known_o (fn_known)
  );

  // An unrecognised function field turns the whole instruction into a bubble
  assign fn_reject = (acl == ACL_FUNC) && !fn_known;

  always_comb begin
    if (fn_reject) begin
      ctl_out  = CTL_OFF;
      alu_op_o = ALU_AND;
    end else begin
      ctl_out  = main_ctl;
      alu_op_o = fn_code;
    end
  end

  assign dst_sel_rd_o  = ctl_out.dst_rd;
  assign opb_imm_o     = ctl_out.opb_imm;
  assign wb_from_mem_o = ctl_out.wb_mem;
  assign rf_we_o       = ctl_out.rf_we;
  assign dm_re_o       = ctl_out.dm_re;
  assign dm_we_o       = ctl_out.dm_we;
  assign br_eq_o       = ctl_out.br;
  assign jmp_o         = ctl_out.jmp;
endmodule

// File: rtl/instr_ctl_decoder_chk.sv
module instr_ctl_decoder_chk
  import ictl_pkg::*;
(
  input logic [OP_W-1:0]  op_i,
  input logic [FN_W-1:0]  fn_i,
  input logic             dst_sel_rd_o,
  input logic             opb_imm_o,
  input logic             wb_from_mem_o,
  input logic             rf_we_o,
  input logic             dm_re_o,
  input logic             dm_we_o,
  input logic             br_eq_o,
  input logic             jmp_o,
  input logic [ALU_W-1:0] alu_op_o,
  input acl_e             acl,
  input logic             op_known,
  input logic             fn_known
);
  logic [7:0] flags;
  assign flags = {dst_sel_rd_o, opb_imm_o, wb_from_mem_o, rf_we_o,
                  dm_re_o, dm_we_o, br_eq_o, jmp_o};

  always_comb begin
    if (!$isunknown({op_i, fn_i})) begin
      p_mem_excl_r10: assert (!(dm_re_o && dm_we_o))
        else $error("memory read and write together");
      p_wb_needs_read_r10: assert (!wb_from_mem_o || dm_re_o)
        else $error("write-back from memory without read");
      p_flow_onehot_r10: assert ($onehot0({br_eq_o, jmp_o}))
        else $error("branch and jump together");
      p_unknown_op_quiet_r8: assert (op_known || (flags == 8'h00 && alu_op_o == ALU_AND))
        else $error("unknown opcode not quiet");
      p_bad_fn_quiet_r9: assert (!(acl == ACL_FUNC && !fn_known) ||
                                 (flags == 8'h00 && alu_op_o == ALU_AND))
        else $error("unknown function code not quiet");
      p_branch_sub_r6: assert (!br_eq_o || alu_op_o == ALU_SUB)
        else $error("branch without subtract");
      p_store_no_wb_r5: assert (!dm_we_o || (!rf_we_o && opb_imm_o && alu_op_o == ALU_ADD))
        else $error("store with register write or wrong operand");
      p_jump_alone_r7: assert (!jmp_o || (flags == 8'h01))
        else $error("jump with other flags");
    end
  end
endmodule

bind instr_ctl_decoder instr_ctl_decoder_chk u_chk (
  .op_i          (op_i),
  .fn_i          (fn_i),
  .dst_sel_rd_o  (dst_sel_rd_o),
  .opb_imm_o     (opb_imm_o),
  .wb_from_mem_o (wb_from_mem_o),
  .rf_we_o       (rf_we_o),
  .dm_re_o       (dm_re_o),
  .dm_we_o       (dm_we_o),
  .br_eq_o       (br_eq_o),
  .jmp_o         (jmp_o),
  .alu_op_o      (alu_op_o),
  .acl           (acl),
  .op_known      (op_known),
  .fn_known      (fn_known)
);

// File: tb/instr_ctl_decoder_tb.sv
module instr_ctl_decoder_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic [5:0] op_r = 6'd0;
  logic [5:0] fn_r = 6'd0;
  logic       dst, opb, wbm, rfwe, dmre, dmwe, br, jmp;
  logic [3:0] alu;
  logic [11:0] got;
  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  instr_ctl_decoder u_dut (
    .op_i          (op_r),
    .fn_i          (fn_r),
    .dst_sel_rd_o  (dst),
    .opb_imm_o     (opb),
    .wb_from_mem_o (wbm),
    .rf_we_o       (rfwe),
    .dm_re_o       (dmre),
    .dm_we_o       (dmwe),
    .br_eq_o       (br),
    .jmp_o         (jmp),
    .alu_op_o      (alu)
  );

  // flag order: dst, opb, wbm, rfwe, dmre, dmwe, br, jmp, then alu
  assign got = {dst, opb, wbm, rfwe, dmre, dmwe, br, jmp, alu};

  localparam logic [7:0] F_REG = 8'b1001_0000;
  localparam logic [7:0] F_LD  = 8'b0111_1000;
  localparam logic [7:0] F_ST  = 8'b0100_0100;
  localparam logic [7:0] F_BEQ = 8'b0000_0010;
  localparam logic [7:0] F_JMP = 8'b0000_0001;

  task automatic apply(input logic [5:0] op, input logic [5:0] fn);
    @(posedge clk);
    #1 {op_r, fn_r} = {op, fn};
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [11:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: op=%0d fn=%h got=%h exp=%h", tag, op_r, fn_r, got, exp);
    end
  endtask

  function automatic logic [11:0] reg_expect(input logic [5:0] fn);
    case (fn)
      6'h20:   return {F_REG, 4'b0010};
      6'h22:   return {F_REG, 4'b0110};
      6'h24:   return {F_REG, 4'b0000};
      6'h25:   return {F_REG, 4'b0001};
      6'h2A:   return {F_REG, 4'b0111};
      default: return 12'h000;
    endcase
  endfunction

  task automatic t_idle;
    apply(6'd0, 6'd0);
    chk("R9 idle op0 fn0 bubble", 12'h000);
  endtask

  task automatic t_rtype;
    apply(6'd0, 6'h20); chk("R2 R3 add",  {F_REG, 4'b0010});
    apply(6'd0, 6'h22); chk("R2 R3 sub",  {F_REG, 4'b0110});
    apply(6'd0, 6'h24); chk("R2 R3 and",  {F_REG, 4'b0000});
    apply(6'd0, 6'h25); chk("R2 R3 or",   {F_REG, 4'b0001});
    apply(6'd0, 6'h2A); chk("R1 R3 slt",  {F_REG, 4'b0111});
  endtask

  task automatic t_rtype_sweep;
    for (int f = 0; f < 64; f++) begin
      apply(6'd0, f[5:0]);
      chk("R9 R3 function sweep", reg_expect(f[5:0]));
    end
  endtask

  task automatic t_load;
    apply(6'd35, 6'h00); chk("R4 load fn00", {F_LD, 4'b0010});
    apply(6'd35, 6'h22); chk("R4 load fn sub ignored", {F_LD, 4'b0010});
    apply(6'd35, 6'h3F); chk("R4 load fn3F ignored", {F_LD, 4'b0010});
  endtask

  task automatic t_store;
    apply(6'd43, 6'h24); chk("R5 store fn and ignored", {F_ST, 4'b0010});
    apply(6'd43, 6'h11); chk("R5 store fn11", {F_ST, 4'b0010});
  endtask

  task automatic t_beq;
    apply(6'd4, 6'h20); chk("R6 beq fn add ignored", {F_BEQ, 4'b0110});
    apply(6'd4, 6'h01); chk("R6 beq fn01", {F_BEQ, 4'b0110});
  endtask

  task automatic t_jump;
    apply(6'd2, 6'h2A); chk("R7 jump fn slt ignored", {F_JMP, 4'b0000});
    apply(6'd2, 6'h00); chk("R7 jump fn00", {F_JMP, 4'b0000});
  endtask

  task automatic t_unknown_op;
    for (int o = 0; o < 64; o++) begin
      if (o != 0 && o != 2 && o != 4 && o != 35 && o != 43) begin
        apply(o[5:0], 6'h20);
        chk("R8 unknown opcode", 12'h000);
      end
    end
  endtask

  task automatic t_mem_rules;
    for (int o = 0; o < 64; o++) begin
      apply(o[5:0], 6'h25);
      checks++;
      if ((dmre && dmwe) || (wbm && !dmre) || (br && jmp)) begin
        errors++;
        $display("FAIL R10 op=%0d got re=%b we=%b wb=%b br=%b j=%b exp exclusive",
                 o, dmre, dmwe, wbm, br, jmp);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_idle();
    t_rtype();
    t_rtype_sweep();
    t_load();
    t_store();
    t_beq();
    t_jump();
    t_unknown_op();
    t_mem_rules();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule